// File: doc/BRIEF.md
# Packed Single-Precision Compare Predicate Unit

This block compares eight lanes of IEEE-754 single-precision values, one vector `opa` against another vector `opb`, under a 5-bit predicate code. Each lane gives a 32-bit result that is all ones when the predicate holds and all zeros when it does not. The result vector is registered and comes out one cycle after the input strobe. A sticky invalid-operation flag records every compare that raised an invalid condition. Software clears this flag with a one-cycle strobe.

The predicate is decoded, not looked up in a table. The two low bits select one of four base relations: equal, less-than, less-or-equal and unordered. Bit 2 inverts the lane result. Bit 3 flips the result only for lanes that hold a NaN. Bit 4 swaps the quiet or signalling behaviour of the base relation, and that behaviour affects only the flag.

Top module: `vec_fcmp_unit`

## Requirements
- R1: With predicate base 0 (equal), two numeric operands give all ones when their bit patterns are identical or when both are zeros of either sign (+0 equals -0), and all zeros otherwise.
- R2: Base 1 (less-than) and base 2 (less-or-equal) order numeric operands by real value across signs, including negative values and infinities. Zeros of opposite sign count as equal.
- R3: A NaN has exponent field all ones and a nonzero mantissa. A lane with a NaN in either operand gives false for bases 0, 1 and 2. Base 3 (unordered) gives true exactly for lanes that hold a NaN.
- R4: Predicate bit 2 (0x04) inverts the lane result for numeric lanes and for NaN lanes alike.
- R5: Predicate bit 3 (0x08) inverts the result only for lanes that hold a NaN. It leaves numeric lanes unchanged. With bits 2 and 3 both set, the numeric result is negated and the NaN result keeps its base value.
- R6: Predicate low nibble 0xB gives all-zero lanes for every input. Low nibble 0xF gives all-ones lanes for every input.
- R7: Lane i uses bits [32i+31:32i] of `opa`, `opb` and `mask`. Lanes are independent, and every lane of `mask` is either 0x00000000 or 0xFFFFFFFF.
- R8: A signalling NaN has a NaN mantissa MSB (bit 22) of 0. An accepted compare sets the flag if any lane has a signalling NaN. It also sets the flag if the predicate is signalling and any lane has a quiet NaN. Bases 1 and 2 signal when bit 4 is 0, and bases 0 and 3 signal when bit 4 is 1. Bit 4 never changes `mask`.
- R9: `invalid_flag` stays set until `flag_clr` is pulsed. When a clear and a new set arrive in the same cycle, the flag ends up set.
- R10: `mask` and `out_valid` update one clock after `in_valid`. `mask` holds its value while `in_valid` is low. Synchronous reset clears `mask`, `out_valid` and `invalid_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and predicate are valid this cycle |
| pred | input | 5 | Predicate code: base in [1:0], invert [2], NaN flip [3], signal swap [4] |
| opa | input | 256 | Eight packed single-precision left operands |
| opb | input | 256 | Eight packed single-precision right operands |
| flag_clr | input | 1 | Clears the sticky invalid flag |
| out_valid | output | 1 | Mask register was loaded in the previous cycle |
| mask | output | 256 | Per-lane all-ones/all-zeros compare result |
| invalid_flag | output | 1 | Sticky invalid-operation status |

## Verification
All 32 predicate codes are run against one mixed vector. That vector holds equal values, strictly ordered pairs in both directions, opposite-sign zeros, negative values, infinities and a quiet NaN on either side. Running every code on it separates the base relations from one another and separates the inverting bit from the NaN-only bit. Targeted vectors follow: an all-zero-sign test, an all-NaN vector, and a vector with a signalling NaN in a single lane. These separate the two NaN kinds and show that bit 4 moves the flag but never the mask. Separate flag sequences check that the flag is sticky, that a clear takes effect, and that a set wins over a clear in the same cycle.

// File: rtl/vfc_pkg.sv
package vfc_pkg;

  typedef enum logic [1:0] {
    BASE_EQ    = 2'd0,
    BASE_LT    = 2'd1,
    BASE_LE    = 2'd2,
    BASE_UNORD = 2'd3
  } base_e;

  typedef struct packed {
    base_e base;
    logic  invert;
    logic  nan_flip;
    logic  signalling;
  } pred_t;

endpackage

// File: rtl/vfc_pred_decode.sv
module vfc_pred_decode
  import vfc_pkg::*;
#(
  parameter int PW = 5
) (
  input  logic [PW-1:0] code,
  output pred_t         dec
);

  logic base_sig_default;

  always_comb begin
    dec.base         = base_e'(code[1:0]);
    dec.invert       = code[2];
    dec.nan_flip     = code[3];
    // less-than style relations are loud by default, the others quiet
    base_sig_default = (code[1:0] == 2'd1) || (code[1:0] == 2'd2);
    dec.signalling   = base_sig_default ^ code[4];
  end

endmodule

// File: rtl/vfc_lane_cmp.sv
module vfc_lane_cmp
  import vfc_pkg::*;
#(
  parameter int EW = 8,
  parameter int MW = 23
) (
  input  logic [EW+MW:0] a,
  input  logic [EW+MW:0] b,
  input  pred_t          p,
  output logic           res,
  output logic           any_nan,
  output logic           any_snan
);

  localparam int W = EW + MW + 1;

  logic          a_sign, b_sign;
  logic [EW-1:0] a_exp, b_exp;
  logic [MW-1:0] a_man, b_man;
  logic [W-2:0]  a_mag, b_mag;
  logic          a_nan, b_nan, a_snan, b_snan;
  logic          both_zero, num_eq, num_lt, num_le;
  logic          base_res;

  always_comb begin
    a_sign = a[W-1];
    b_sign = b[W-1];
    a_exp  = a[W-2:MW];
    b_exp  = b[W-2:MW];
    a_man  = a[MW-1:0];
    b_man  = b[MW-1:0];
    a_mag  = a[W-2:0];
    b_mag  = b[W-2:0];

    a_nan  = (&a_exp) && (|a_man);
    b_nan  = (&b_exp) && (|b_man);
    a_snan = a_nan && !a_man[MW-1];
    b_snan = b_nan && !b_man[MW-1];
    any_nan  = a_nan || b_nan;
    any_snan = a_snan || b_snan;

    both_zero = (a_mag == '0) && (b_mag == '0);
    num_eq    = both_zero || (a == b);

    if (both_zero)             num_lt = 1'b0;
    else if (a_sign != b_sign) num_lt = a_sign;
    else if (!a_sign)          num_lt = a_mag < b_mag;
    else                       num_lt = a_mag > b_mag;
    num_le = num_lt || num_eq;

    if (any_nan) begin
      base_res = (p.base == BASE_UNORD);
    end else begin
      unique case (p.base)
        BASE_EQ: base_res = num_eq;
        BASE_LT: base_res = num_lt;
        BASE_LE: base_res = num_le;
        default: base_res = 1'b0;
      endcase
    end

    res = base_res ^ p.invert ^ (any_nan & p.nan_flip);
  end

endmodule

// File: rtl/vfc_sticky_flag.sv
module vfc_sticky_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic flag
);

  always_ff @(posedge clk) begin
    if (rst)      flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    set |=> flag); // R9

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (flag && !clr) |=> flag); // R9

  AST_CLR_DROPS: assert property (@(posedge clk) disable iff (rst)
    (clr && !set) |=> !flag); // R9

endmodule

// File: rtl/vec_fcmp_unit.sv
module vec_fcmp_unit
  import vfc_pkg::*;
#(
  parameter int LANES = 8,
  parameter int EW    = 8,
  parameter int MW    = 23,
  parameter int PW    = 5
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          in_valid,
  input  logic [PW-1:0]                 pred,
  input  logic [LANES*(EW+MW+1)-1:0]    opa,
  input  logic [LANES*(EW+MW+1)-1:0]    opb,
  input  logic                          flag_clr,
  output logic                          out_valid,
  output logic [LANES*(EW+MW+1)-1:0]    mask,
  output logic                          invalid_flag
);

  localparam int W  = EW + MW + 1;
  localparam int VW = LANES * W;

  pred_t            dec;
  logic [LANES-1:0] lane_res, lane_nan, lane_snan;
  logic [VW-1:0]    mask_d;
  logic             flag_set;

  vfc_pred_decode #(.PW(PW)) u_dec (
    .code (pred),
    .dec  (dec)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    vfc_lane_cmp #(.EW(EW), .MW(MW)) u_lane (
      .a        (opa[i*W +: W]),
      .b        (opb[i*W +: W]),
      .p        (dec),
      .res      (lane_res[i]),
      .any_nan  (lane_nan[i]),
      .any_snan (lane_snan[i])
    );
    assign mask_d[i*W +: W] = {W{lane_res[i]}};

    AST_LANE_UNIFORM: assert property (@(posedge clk) disable iff (rst)
      (mask[i*W +: W] == '0) || (mask[i*W +: W] == '1)); // R7
  end

  assign flag_set = in_valid && ((|lane_snan) || (dec.signalling && (|lane_nan)));

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      mask      <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) mask <= mask_d;
    end
  end

  vfc_sticky_flag u_flag (
    .clk  (clk),
    .rst  (rst),
    .set  (flag_set),
    .clr  (flag_clr),
    .flag (invalid_flag)
  );

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R10

  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid); // R10

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(mask)); // R10

  AST_CODE_FALSE: assert property (@(posedge clk) disable iff (rst)
    (in_valid && pred[3:0] == 4'hB) |=> (mask == '0)); // R6

  AST_CODE_TRUE: assert property (@(posedge clk) disable iff (rst)
    (in_valid && pred[3:0] == 4'hF) |=> (&mask)); // R6

endmodule

// File: tb/vec_fcmp_unit_tb.sv
`timescale 1ns/1ps
module vec_fcmp_unit_tb;

  localparam logic [31:0] P1 = 32'h3F80_0000, P2 = 32'h4000_0000;
  localparam logic [31:0] N1 = 32'hBF80_0000, N3 = 32'hC040_0000;
  localparam logic [31:0] PZ = 32'h0000_0000, NZ = 32'h8000_0000;
  localparam logic [31:0] QN = 32'h7FC0_0000, SN = 32'h7F80_0001;
  localparam logic [31:0] PI = 32'h7F80_0000, NI = 32'hFF80_0000;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [4:0]   pred = '0;
  logic [255:0] opa = '0, opb = '0;
  logic         flag_clr = 1'b0;
  logic         out_valid;
  logic [255:0] mask;
  logic         invalid_flag;

  int checks = 0, fails = 0;
  logic exp_flag = 1'b0;
  logic [31:0] va [8];
  logic [31:0] vb [8];

  always #10 clk = ~clk;

  vec_fcmp_unit u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .pred(pred),
    .opa(opa), .opb(opb), .flag_clr(flag_clr),
    .out_valid(out_valid), .mask(mask), .invalid_flag(invalid_flag)
  );

  function automatic logic is_nan(input logic [31:0] x);
    return (x[30:23] == 8'hFF) && (x[22:0] != 0);
  endfunction

  function automatic logic [31:0] okey(input logic [31:0] x);
    if (x[30:0] == 0) return 32'h8000_0000;
    return x[31] ? ~x : (x | 32'h8000_0000);
  endfunction

  function automatic logic ref_lane(input logic [4:0] p, input logic [31:0] a, input logic [31:0] b);
    logic n, r;
    n = is_nan(a) || is_nan(b);
    case (p[1:0])
      2'd0: r = !n && (okey(a) == okey(b));
      2'd1: r = !n && (okey(a) <  okey(b));
      2'd2: r = !n && (okey(a) <= okey(b));
      default: r = n;
    endcase
    r = r ^ p[2];
    if (n) r = r ^ p[3];
    return r;
  endfunction

  task automatic chk(input string tag, input logic [255:0] got, input logic [255:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic run_vec(input logic [4:0] p, input string tag);
    logic [255:0] em;
    logic sn, qn, sig;
    sn = 0; qn = 0;
    for (int i = 0; i < 8; i++) begin
      em[i*32 +: 32] = {32{ref_lane(p, va[i], vb[i])}};
      if (is_nan(va[i]) && !va[i][22]) sn = 1;
      if (is_nan(vb[i]) && !vb[i][22]) sn = 1;
      if (is_nan(va[i]) || is_nan(vb[i])) qn = 1;
    end
    sig = ((p[1:0] == 2'd1) || (p[1:0] == 2'd2)) ^ p[4];
    @(negedge clk);
    in_valid = 1; pred = p;
    for (int i = 0; i < 8; i++) begin
      opa[i*32 +: 32] = va[i];
      opb[i*32 +: 32] = vb[i];
    end
    @(negedge clk);
    in_valid = 0;
    exp_flag = exp_flag | sn | (sig & qn);
    chk({tag, " mask"}, mask, em);
    chk("R10 out_valid", {255'd0, out_valid}, 256'd1);
    chk({tag, " flag"}, {255'd0, invalid_flag}, {255'd0, exp_flag});
  endtask

  task automatic clear_flag();
    @(negedge clk); flag_clr = 1;
    @(negedge clk); flag_clr = 0;
    exp_flag = 0;
    chk("R9 clear", {255'd0, invalid_flag}, 256'd0);
  endtask

  task automatic t_reset();
    chk("R10 reset mask", mask, '0);
    chk("R10 reset valid", {255'd0, out_valid}, 256'd0);
    chk("R10 reset flag", {255'd0, invalid_flag}, 256'd0);
  endtask

  task automatic t_zero_equal();
    for (int i = 0; i < 8; i++) begin va[i] = (i % 2) ? NZ : PZ; vb[i] = (i % 2) ? PZ : NZ; end
    run_vec(5'h00, "R1");
    chk("R1 zeros literal", mask, {256{1'b1}});
    run_vec(5'h01, "R2");
    chk("R2 zeros not lt", mask, '0);
  endtask

  task automatic set_mix();
    va[0] = P1; vb[0] = P1;
    va[1] = P1; vb[1] = P2;
    va[2] = P2; vb[2] = P1;
    va[3] = NZ; vb[3] = PZ;
    va[4] = QN; vb[4] = P1;
    va[5] = P1; vb[5] = QN;
    va[6] = N3; vb[6] = N1;
    va[7] = PI; vb[7] = NI;
  endtask

  task automatic t_sweep();
    set_mix();
    for (int c = 0; c < 32; c++) begin
      run_vec(c[4:0], "R7 sweep");
      clear_flag();
    end
    run_vec(5'h01, "R2 mix");
    chk("R2 lt literal", mask, {32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'hFFFFFFFF, 32'h0} |
                               {32'h0, 32'hFFFFFFFF, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0});
    clear_flag();
  endtask

  task automatic t_nan_paths();
    for (int i = 0; i < 8; i++) begin va[i] = QN; vb[i] = (i < 4) ? QN : P2; end
    run_vec(5'h02, "R3 le on nan");
    chk("R3 le nan literal", mask, '0);
    run_vec(5'h03, "R3 unord");
    chk("R3 unord literal", mask, {256{1'b1}});
    run_vec(5'h05, "R4 nlt");
    chk("R4 nlt literal", mask, {256{1'b1}});
    run_vec(5'h0D, "R5 ge on nan");
    chk("R5 ge nan literal", mask, '0);
    clear_flag();
  endtask

  task automatic t_constants();
    set_mix();
    run_vec(5'h0B, "R6 false");
    chk("R6 false literal", mask, '0);
    run_vec(5'h1F, "R6 true");
    chk("R6 true literal", mask, {256{1'b1}});
    clear_flag();
  endtask

  task automatic t_flag_kinds();
    logic [255:0] m0;
    for (int i = 0; i < 8; i++) begin va[i] = P1; vb[i] = P2; end
    va[3] = QN;
    run_vec(5'h00, "R8 quiet eq no flag");
    chk("R8 quiet literal", {255'd0, invalid_flag}, 256'd0);
    m0 = mask;
    run_vec(5'h10, "R8 eq signalling");
    chk("R8 bit4 mask unchanged", mask, m0);
    chk("R8 signalling literal", {255'd0, invalid_flag}, 256'd1);
    clear_flag();
    run_vec(5'h11, "R8 lt quiet");
    chk("R8 lt quiet literal", {255'd0, invalid_flag}, 256'd0);
    va[3] = SN;
    run_vec(5'h03, "R8 snan any pred");
    chk("R8 snan literal", {255'd0, invalid_flag}, 256'd1);
  endtask

  task automatic t_sticky();
    for (int i = 0; i < 8; i++) begin va[i] = P1; vb[i] = P1; end
    run_vec(5'h00, "R9 stays set");
    chk("R9 sticky literal", {255'd0, invalid_flag}, 256'd1);
    va[0] = SN;
    @(negedge clk);
    in_valid = 1; pred = 5'h00; flag_clr = 1;
    opa[31:0] = SN;
    @(negedge clk);
    in_valid = 0; flag_clr = 0;
    chk("R9 set wins", {255'd0, invalid_flag}, 256'd1);
    clear_flag();
  endtask

  task automatic t_hold();
    logic [255:0] m0;
    set_mix();
    run_vec(5'h02, "R10 load");
    m0 = mask;
    @(negedge clk);
    opa = ~opa; pred = 5'h0F;
    @(negedge clk);
    chk("R10 hold mask", mask, m0);
    chk("R10 idle valid", {255'd0, out_valid}, 256'd0);
    clear_flag();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R10 watchdog expired got running expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_zero_equal();
    clear_flag();
    t_sweep();
    t_nan_paths();
    t_constants();
    t_flag_kinds();
    t_sticky();
    t_hold();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule